// File: doc/BRIEF.md
# Stored-Pattern Sensor Sync Sequencer

This block generates the sync lines of an image sensor by replaying a timing table held in an external nonvolatile memory. The table sits in several byte-wide devices that share one address bus. Their read buses are joined side by side into one sync word, so each bit of the word drives one sync line. A counter presents one address per sub-pixel step. At the default 16.66 MHz clock a step lasts 60 ns, and the default frame length of 1,116,667 steps is about 67 ms. The word read back is registered onto the outputs. When the counter reaches a programmable terminal count it returns to zero, and the frame repeats without a break.

A host controller can take over the memory bus to load or refresh the table while the block is running. A request is honoured only at the end of a frame. While the host owns the bus, the sync lines rest at a programmable idle word. The host moves data into the memory over a valid/ready write channel. Ready is high only while the host holds the bus, and a write happens on every cycle where valid and ready are both high. Before the grant, ready stays low and the host must keep its write pending. When the host drops its request, playback restarts at address zero. The terminal count and the idle word are loaded through plain write strobes.

Top module: `sync_pattern_player`

## Requirements
- R1: While reset is high, and on the first cycle after it, sync_out equals the IDLE_RST parameter, frame_start is 0, host_grant is 0, host_wr_ready is 0, mem_we is 0 and mem_addr is 0.
- R2: During playback, mem_addr rises by exactly one per clock unless the wrap condition of R4 holds.
- R3: During playback, sync_out in each cycle equals the mem_rdata word that was present one clock earlier, bit for bit. Device k drives bits [8k+7:8k], so device 0 is the low byte.
- R4: In a playback cycle where mem_addr is greater than or equal to the terminal count, the next address is 0. This also covers a terminal count lowered below the current address.
- R5: frame_start is 1 exactly in the cycles where sync_out carries the word read from address 0, and 0 at all other times.
- R6: host_grant rises only in the cycle after a playback cycle that meets the wrap condition while host_req is high. A request made at any other time waits. The grant stays high while host_req stays high.
- R7: While host_grant is high, mem_addr equals host_wr_addr, host_wr_ready is 1 and mem_we equals host_wr_valid, with mem_wdata taken from host_wr_data. While host_grant is low, host_wr_ready and mem_we are 0.
- R8: When host_req is low in a cycle where the host holds the bus, host_grant falls on the next clock and playback resumes at address 0.
- R9: The terminal count resets to the DEF_TC parameter (default 1,116,666). A cfg_tc_we pulse loads cfg_tc, and the new value takes effect from the next cycle.
- R10: While the host holds the bus, sync_out equals the idle word. The idle word resets to IDLE_RST, and a cfg_idle_we pulse loads cfg_idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one sub-pixel step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host asks for the memory bus (level) |
| host_grant | output | 1 | Host owns the memory bus |
| host_wr_valid | input | 1 | Host write beat present |
| host_wr_ready | output | 1 | Write beat accepted this cycle |
| host_wr_addr | input | AW (21) | Host write address |
| host_wr_data | input | NDEV*DW (16) | Host write word |
| cfg_tc_we | input | 1 | Load the terminal count |
| cfg_tc | input | AW (21) | New terminal count |
| cfg_idle_we | input | 1 | Load the idle word |
| cfg_idle | input | NDEV*DW (16) | New idle word |
| mem_addr | output | AW (21) | Shared address of the memory devices |
| mem_we | output | 1 | Write strobe to all devices |
| mem_wdata | output | NDEV*DW (16) | Write data, byte k to device k |
| mem_rdata | input | NDEV*DW (16) | Joined read data, byte k from device k |
| sync_out | output | NDEV*DW (16) | Registered sync lines |
| frame_start | output | 1 | Marks the step that carries word 0 |

## Verification
The assertions assume the terminal count is at least 1. A count of 0 would make every step a frame start, and the single-step frame_start check would then fail. They also assume that host_req is a level that is held until the grant arrives, and that the memory answers a read in the same cycle the address is presented.

The randomised stimulus loads only terminal counts from 1 to 63 and keeps host addresses inside the modelled memory. It toggles host_req rarely, so requests often arrive in the middle of a frame and have to wait. Some terminal-count loads fall below the running address, which exercises the late-wrap case.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic {
    OWN_PLAY = 1'b0,
    OWN_HOST = 1'b1
  } owner_e;
endpackage

// File: rtl/sps_addr_gen.sv
module sps_addr_gen #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [AW-1:0] tc,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // ">=" rather than "==" so a lowered count still wraps
  assign at_end = (addr >= tc);

  always_ff @(posedge clk) begin
    if (rst || !run) addr <= '0;
    else if (at_end) addr <= '0;
    else             addr <= addr + ONE;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !at_end) |=> (addr == $past(addr) + ONE));
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && at_end) |=> (addr == '0));
  a_r8_park_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (addr == '0));
endmodule

// File: rtl/sps_arbiter.sv
module sps_arbiter
  import sps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   host_req,
  input  logic   at_end,
  output owner_e owner
);
  owner_e owner_nx;

  always_comb begin
    owner_nx = owner;
    unique case (owner)
      OWN_PLAY: if (at_end && host_req) owner_nx = OWN_HOST;
      OWN_HOST: if (!host_req)          owner_nx = OWN_PLAY;
      default:                          owner_nx = OWN_PLAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_PLAY;
    else     owner <= owner_nx;
  end

  a_r6_grant_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_PLAY && !at_end) |=> (owner == OWN_PLAY));
  a_r6_grant_held: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_HOST && host_req) |=> (owner == OWN_HOST));
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_HOST && !host_req) |=> (owner == OWN_PLAY));
endmodule

// File: rtl/sps_bus_mux.sv
module sps_bus_mux
  import sps_pkg::*;
#(
  parameter int AW   = 21,
  parameter int DW   = 8,
  parameter int NDEV = 2,
  localparam int SW  = DW * NDEV
) (
  input  owner_e        owner,
  input  logic [AW-1:0] play_addr,
  input  logic [AW-1:0] host_addr,
  input  logic          host_valid,
  input  logic [SW-1:0] host_data,
  output logic          host_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [SW-1:0] mem_wdata,
  input  logic [SW-1:0] mem_rdata,
  output logic [SW-1:0] rd_word
);
  logic host_side;
  assign host_side  = (owner == OWN_HOST);
  assign host_ready = host_side;
  assign mem_addr   = host_side ? host_addr : play_addr;
  assign mem_we     = host_side && host_valid;

  // one byte lane per device; lane k feeds bits [k*DW +: DW]
  for (genvar k = 0; k < NDEV; k++) begin : g_lane
    assign mem_wdata[k*DW +: DW] = host_data[k*DW +: DW];
    assign rd_word[k*DW +: DW]   = mem_rdata[k*DW +: DW];
  end

  always_comb begin
    if (!host_side) a_r7_no_write_in_play: assert (!mem_we && !host_ready);
  end
endmodule

// File: rtl/sps_out_stage.sv
module sps_out_stage
  import sps_pkg::*;
#(
  parameter int          SW       = 16,
  parameter logic [SW-1:0] IDLE_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  owner_e        owner,
  input  logic [SW-1:0] rd_word,
  input  logic          addr_zero,
  input  logic [SW-1:0] idle_word,
  output logic [SW-1:0] sync_out,
  output logic          frame_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out    <= IDLE_RST;
      frame_start <= 1'b0;
    end else if (owner == OWN_HOST) begin
      sync_out    <= idle_word;
      frame_start <= 1'b0;
    end else begin
      sync_out    <= rd_word;
      frame_start <= addr_zero;
    end
  end

  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_PLAY) |=> (sync_out == $past(rd_word)));
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_HOST) |=> (sync_out == $past(idle_word) && !frame_start));
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

// File: rtl/sync_pattern_player.sv
module sync_pattern_player
  import sps_pkg::*;
#(
  parameter int AW   = 21,
  parameter int DW   = 8,
  parameter int NDEV = 2,
  parameter int DEF_TC = 1116666,
  parameter logic [DW*NDEV-1:0] IDLE_RST = '0,
  localparam int SW  = DW * NDEV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  output logic          host_grant,
  input  logic          host_wr_valid,
  output logic          host_wr_ready,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [SW-1:0] host_wr_data,
  input  logic          cfg_tc_we,
  input  logic [AW-1:0] cfg_tc,
  input  logic          cfg_idle_we,
  input  logic [SW-1:0] cfg_idle,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [SW-1:0] mem_wdata,
  input  logic [SW-1:0] mem_rdata,
  output logic [SW-1:0] sync_out,
  output logic          frame_start
);
  localparam logic [AW-1:0] TC_RST = AW'(DEF_TC);

  logic [AW-1:0] tc_q;
  logic [SW-1:0] idle_q;
  logic [AW-1:0] play_addr;
  logic          at_end;
  logic [SW-1:0] rd_word;
  owner_e        owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= TC_RST;
      idle_q <= IDLE_RST;
    end else begin
      if (cfg_tc_we)   tc_q   <= cfg_tc;
      if (cfg_idle_we) idle_q <= cfg_idle;
    end
  end

  sps_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .run(owner == OWN_PLAY), .tc(tc_q),
    .addr(play_addr), .at_end(at_end)
  );

  sps_arbiter u_arb (
    .clk(clk), .rst(rst), .host_req(host_req), .at_end(at_end), .owner(owner)
  );

  sps_bus_mux #(.AW(AW), .DW(DW), .NDEV(NDEV)) u_mux (
    .owner(owner), .play_addr(play_addr), .host_addr(host_wr_addr),
    .host_valid(host_wr_valid), .host_data(host_wr_data),
    .host_ready(host_wr_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_word(rd_word)
  );

  sps_out_stage #(.SW(SW), .IDLE_RST(IDLE_RST)) u_out (
    .clk(clk), .rst(rst), .owner(owner), .rd_word(rd_word),
    .addr_zero(play_addr == '0), .idle_word(idle_q),
    .sync_out(sync_out), .frame_start(frame_start)
  );

  assign host_grant = (owner == OWN_HOST);

  a_r9_tc_load: assert property (@(posedge clk) disable iff (rst)
    cfg_tc_we |=> (tc_q == $past(cfg_tc)));
  a_r7_we_follows_valid: assert property (@(posedge clk) disable iff (rst)
    host_grant |-> (mem_we == host_wr_valid && mem_addr == host_wr_addr));
endmodule

// File: tb/sync_pattern_player_tb.sv
module sync_pattern_player_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21, DW = 8, NDEV = 2, SW = 16;
  localparam int DEF_TC = 37;
  localparam logic [SW-1:0] IDLE_R = 16'hA5C3;

  logic clk = 0, rst = 1;
  logic host_req = 0, host_wr_valid = 0, cfg_tc_we = 0, cfg_idle_we = 0;
  logic [AW-1:0] host_wr_addr = '0, cfg_tc = '0;
  logic [SW-1:0] host_wr_data = '0, cfg_idle = '0;
  logic host_grant, host_wr_ready, mem_we, frame_start;
  logic [AW-1:0] mem_addr;
  logic [SW-1:0] mem_wdata, mem_rdata, sync_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pattern_player #(.AW(AW), .DW(DW), .NDEV(NDEV), .DEF_TC(DEF_TC),
                        .IDLE_RST(IDLE_R)) u_dut (.*);

  // external memory devices: device 0 low byte, device 1 high byte
  logic [SW-1:0] ext_mem [256];
  logic [SW-1:0] ref_mem [256];
  assign mem_rdata = ext_mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) ext_mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [SW-1:0] seed_word(int a);
    return {8'(a * 7 + 3) ^ 8'h3C, 8'(~a)};
  endfunction

  initial for (int i = 0; i < 256; i++) begin
    ext_mem[i] = seed_word(i);
    ref_mem[i] = seed_word(i);
  end

  // reference model, from the requirements
  logic          m_own;
  logic [AW-1:0] m_a, m_tc;
  logic [SW-1:0] m_sync, m_idle;
  logic          m_fs;
  always @(posedge clk) begin
    if (rst) begin
      m_own = 0; m_a = '0; m_sync = IDLE_R; m_fs = 0;
      m_tc = AW'(DEF_TC); m_idle = IDLE_R;
    end else begin
      if (!m_own) begin
        m_sync = ref_mem[m_a[7:0]];
        m_fs = (m_a == '0);
        if (m_a >= m_tc) begin
          m_a = '0;
          if (host_req) m_own = 1;
        end else m_a = m_a + 1'b1;
      end else begin
        m_sync = m_idle;
        m_fs = 0;
        if (host_wr_valid) ref_mem[host_wr_addr[7:0]] = host_wr_data;
        if (!host_req) begin m_own = 0; m_a = '0; end
      end
      if (cfg_tc_we)   m_tc = cfg_tc;
      if (cfg_idle_we) m_idle = cfg_idle;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // sampled away from the active edge
  always @(negedge clk) if (!done && m_own !== 1'bx) begin
    if (rst) begin
      chk("R1 sync", 32'(sync_out), 32'(IDLE_R));
      chk("R1 fs", 32'(frame_start), 0);
      chk("R1 grant", 32'(host_grant), 0);
      chk("R1 addr", 32'(mem_addr), 0);
      chk("R1 we", 32'(mem_we), 0);
    end else begin
      chk(m_own ? "R7 R10 idle" : "R3 data", 32'(sync_out), 32'(m_sync));
      chk("R5 fs", 32'(frame_start), 32'(m_fs));
      chk("R6 R8 grant", 32'(host_grant), 32'(m_own));
      chk(m_own ? "R7 addr" : "R2 R4 R9 addr", 32'(mem_addr),
          32'(m_own ? host_wr_addr : m_a));
      chk("R7 we", 32'(mem_we), 32'(m_own && host_wr_valid));
      chk("R7 ready", 32'(host_wr_ready), 32'(m_own));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    step(4);
    rst = 0;
    // R9 default terminal count; R4 wraps twice
    step(90);
    // directed: short frame, request mid-frame (R6), writes (R7), release (R8)
    cfg_tc = 21'd9; cfg_tc_we = 1; step(); cfg_tc_we = 0;
    step(3);
    host_req = 1;
    for (int i = 0; i < 12; i++) begin
      host_wr_valid = 1; host_wr_addr = 21'(i % 10);
      host_wr_data = 16'($urandom); step();
    end
    host_wr_valid = 0;
    cfg_idle = 16'h0F0F; cfg_idle_we = 1; step(); cfg_idle_we = 0;  // R10
    step(5);
    host_req = 0;
    step(30);
    // R4: count lowered below the running address
    cfg_tc = 21'd30; cfg_tc_we = 1; step(); cfg_tc_we = 0;
    step(25);
    cfg_tc = 21'd4; cfg_tc_we = 1; step(); cfg_tc_we = 0;
    step(20);
    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(19) == 0) host_req = ~host_req;
      host_wr_valid = $urandom_range(1);
      host_wr_addr  = 21'($urandom_range(63));
      host_wr_data  = 16'($urandom);
      cfg_tc_we     = ($urandom_range(49) == 0);
      cfg_tc        = 21'($urandom_range(63, 1));
      cfg_idle_we   = ($urandom_range(39) == 0);
      cfg_idle      = 16'($urandom);
      step();
    end
    host_req = 0; host_wr_valid = 0; cfg_tc_we = 0; cfg_idle_we = 0;
    step(80);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule